// File: doc/BRIEF.md
# Quarter-Rate Digital I/Q Mixer

This block takes the one-bit output stream of a bandpass delta-sigma modulator tuned to one quarter of the sample rate. It translates that stream down to baseband as in-phase and quadrature sample streams, and it uses no multiplier to do so. A two-bit phase counter drives a decoder that produces exact cosine and sine references. Both references take only the values +1, 0 and −1. Each incoming bit is mapped to a signed two-bit value. A selector then passes that value, zeroes it or negates it according to each reference.

The counter advances only on samples flagged valid. The I and Q products are registered together with a matching valid strobe, so each accepted bit produces exactly one output pair one clock later. The outputs keep the full input rate. Decimation and filtering happen downstream.

Top module: `qmix_quarter_rate`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `out_valid` is 0 and both `i_out` and `q_out` are 00. The reference phase returns to index 0.
- R2: An input bit of 1 stands for +1 and is converted to 01. An input bit of 0 stands for −1 and is converted to 11.
- R3: The cosine reference over consecutive accepted samples, starting at phase 0, is +1, 0, −1, 0 and then repeats. This gives `i_out` = s, 00, −s, 00 for converted sample s.
- R4: The sine reference is the cosine reference one accepted sample later: 0, +1, 0, −1 and then repeats. This gives `q_out` = 00, s, 00, −s.
- R5: Whenever a reference is 0, the matching output is 00 regardless of the input bit.
- R6: Whenever a reference is −1, the output is the two's-complement negation of the converted sample (01 becomes 11, 11 becomes 01).
- R7: `out_valid` in cycle n+1 equals `in_valid` in cycle n (outside reset), and the outputs carry the product of the bit sampled in cycle n.
- R8: A cycle with `in_valid` low does not advance the phase. In the following cycle `out_valid` is 0 and `i_out`/`q_out` hold their previous values.
- R9: Every valid output pair has exactly one nonzero member, and no output ever shows the code 10.
- R10: A reset applied in the middle of a stream restarts the reference sequences at phase 0 for the next accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_bit` and advances the reference phase |
| in_bit | input | 1 | Modulator output bit (1 = +1, 0 = −1) |
| out_valid | output | 1 | Marks a new I/Q pair |
| i_out | output | 2 | In-phase product, two's complement |
| q_out | output | 2 | Quadrature product, two's complement |

## Verification
A wrong phase count or a stuck reference does not show up as a single bad value. It shows up as the zero slot moving between I and Q, or as a sign in the wrong position. Either fault is visible on the first or second valid pair after the error. A counter that advances on idle cycles shifts every later pair by one phase, so the bench interleaves gaps with data. It also follows the phase through mid-stream resets, so that a slip appears within four samples.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
   localparam int SAMPLE_W = 2;
   typedef logic signed [SAMPLE_W-1:0] tri_t;
   localparam tri_t TRI_POS  = 2'sb01;
   localparam tri_t TRI_ZERO = 2'sb00;
   localparam tri_t TRI_NEG  = 2'sb11;

   function automatic tri_t bit_to_tri(input logic b, input logic one_is_pos);
      return (b == one_is_pos) ? TRI_POS : TRI_NEG;
   endfunction
endpackage

// File: rtl/qmix_lo.sv
module qmix_lo
   import qmix_pkg::*;
#(
   parameter int PHASE_W      = 2,
   parameter bit SIN_BY_DELAY = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output tri_t cos_ref,
   output tri_t sin_ref
);
   localparam int PHASES = 1 << PHASE_W;

   logic [PHASE_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst)      phase_q <= '0;
      else if (adv) phase_q <= phase_q + 1'b1;
   end

   function automatic tri_t cos_of(input logic [PHASE_W-1:0] p);
      tri_t r;
      unique case (p)
         2'd0:    r = TRI_POS;
         2'd2:    r = TRI_NEG;
         default: r = TRI_ZERO;
      endcase
      return r;
   endfunction

   assign cos_ref = cos_of(phase_q);

   generate
      if (PHASES != 4) begin : g_bad_phase
         $error("qmix_lo: PHASE_W must be 2 for a quarter-rate reference");
      end
      if (SIN_BY_DELAY) begin : g_sin_delay
         tri_t sin_q;
         always_ff @(posedge clk) begin
            if (rst)      sin_q <= TRI_ZERO;
            else if (adv) sin_q <= cos_ref;
         end
         assign sin_ref = sin_q;
      end else begin : g_sin_decode
         assign sin_ref = cos_of(phase_q - 1'b1);
      end
   endgenerate
endmodule

// File: rtl/qmix_sel.sv
module qmix_sel
   import qmix_pkg::*;
(
   input  tri_t sample,
   input  tri_t ref_val,
   output tri_t prod
);
   always_comb begin
      unique case (ref_val)
         TRI_POS: prod = sample;
         TRI_NEG: prod = -sample;
         default: prod = TRI_ZERO;
      endcase
   end
endmodule

// File: rtl/qmix_quarter_rate.sv
module qmix_quarter_rate
   import qmix_pkg::*;
#(
   parameter int PHASE_W        = 2,
   parameter bit SIN_BY_DELAY   = 1'b1,
   parameter bit BIT_ONE_IS_POS = 1'b1,
   parameter int LANES          = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       in_valid,
   input  logic       in_bit,
   output logic       out_valid,
   output logic [1:0] i_out,
   output logic [1:0] q_out
);
   generate
      if (LANES != 2) begin : g_bad_lanes
         $error("qmix_quarter_rate: exactly two lanes (I and Q) are supported");
      end
   endgenerate

   tri_t refs  [LANES];
   tri_t prods [LANES];
   tri_t regs  [LANES];
   tri_t sample;
   logic vld_q;

   assign sample = bit_to_tri(in_bit, BIT_ONE_IS_POS);

   qmix_lo #(.PHASE_W(PHASE_W), .SIN_BY_DELAY(SIN_BY_DELAY)) lo_i (
      .clk(clk), .rst(rst), .adv(in_valid),
      .cos_ref(refs[0]), .sin_ref(refs[1])
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         qmix_sel sel_i (.sample(sample), .ref_val(refs[l]), .prod(prods[l]));
         always_ff @(posedge clk) begin
            if (rst)           regs[l] <= TRI_ZERO;
            else if (in_valid) regs[l] <= prods[l];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_valid;
   end

   assign out_valid = vld_q;
   assign i_out     = regs[0];
   assign q_out     = regs[1];
endmodule

// File: rtl/qmix_chk.sv
module qmix_chk (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       out_valid,
   input logic [1:0] i_out,
   input logic [1:0] q_out
);
   logic rst_seen = 1'b0;
   always_ff @(posedge clk) rst_seen <= rst;

   // R1: outputs cleared in the cycle after reset
   always @(negedge clk)
      if (rst_seen) p_reset_clear_r1: assert (!out_valid && i_out == 2'b00 && q_out == 2'b00);

   p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_idle_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(i_out) && $stable(q_out)));
   p_no_code10_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (i_out != 2'b10 && q_out != 2'b10));
   p_one_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((i_out == 2'b00) != (q_out == 2'b00)));
endmodule

bind qmix_quarter_rate qmix_chk chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid),
   .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
);

// File: tb/qmix_quarter_rate_tb_top.sv
module qmix_quarter_rate_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic out_valid;
   logic [1:0] i_out, q_out;

   int checks = 0;
   int errors = 0;
   int phase  = 0;
   bit finished = 1'b0;
   logic [3:0] exp_q[$];
   logic exp_valid = 1'b0;
   logic rst_prev  = 1'b1;
   logic [1:0] last_i = 2'b00, last_q = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   qmix_quarter_rate dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
      .out_valid(out_valid), .i_out(i_out), .q_out(q_out)
   );

   function automatic logic [1:0] mix(input logic b, input int r);
      logic [1:0] s;
      s = b ? 2'b01 : 2'b11;         // R2 encoding
      if (r == 0) return 2'b00;      // R5
      if (r > 0)  return s;
      return (s == 2'b01) ? 2'b11 : 2'b01; // R6
   endfunction

   function automatic int cos_ref(input int p);  // R3
      case (p) 0: return 1; 2: return -1; default: return 0; endcase
   endfunction

   function automatic int sin_ref(input int p);  // R4
      case (p) 1: return 1; 3: return -1; default: return 0; endcase
   endfunction

   task automatic send(input logic b, input logic v);
      @(negedge clk);
      in_bit = b; in_valid = v;
      if (v) begin
         exp_q.push_back({mix(b, cos_ref(phase)), mix(b, sin_ref(phase))});
         phase = (phase + 1) % 4;
      end
   endtask

   task automatic do_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      for (int k = 0; k < n; k++) begin
         in_valid = 1'b1; in_bit = k[0];
         @(negedge clk);
      end
      rst = 1'b0; in_valid = 1'b0;
      exp_q.delete();
      phase = 0;  // R10
   endtask

   always @(posedge clk) begin
      exp_valid <= in_valid & ~rst;
      rst_prev  <= rst;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL R7 out_valid actual %b expected %b", out_valid, exp_valid);
         end
         if (rst_prev) begin
            checks++;
            if (out_valid !== 1'b0 || i_out !== 2'b00 || q_out !== 2'b00) begin
               errors++;
               $display("FAIL R1 reset state actual v=%b i=%b q=%b expected 0 00 00",
                        out_valid, i_out, q_out);
            end
            last_i = 2'b00; last_q = 2'b00;
         end else if (out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R7 unexpected output actual i=%b q=%b expected none", i_out, q_out);
            end else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               if ({i_out, q_out} !== e) begin
                  errors++;
                  $display("FAIL R3/R4 mix actual i=%b q=%b expected i=%b q=%b",
                           i_out, q_out, e[3:2], e[1:0]);
               end
            end
            last_i = i_out; last_q = q_out;
         end else begin
            checks++;
            if (i_out !== last_i || q_out !== last_q) begin
               errors++;
               $display("FAIL R8 hold actual i=%b q=%b expected i=%b q=%b",
                        i_out, q_out, last_i, last_q);
            end
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!finished && cyc < WATCHDOG) begin
         @(posedge clk); cyc++;
      end
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset(3);                                   // R1
      for (int k = 0; k < 12; k++) send(1'b1, 1'b1); // R2 R3 R4 R5 with +1 input
      for (int k = 0; k < 12; k++) send(1'b0, 1'b1); // R2 R6 with -1 input
      for (int k = 0; k < 20; k++) send(k[1] ^ k[0], 1'b1); // mixed pattern R9
      for (int k = 0; k < 24; k++) send(k[2], (k % 3) != 1); // gaps R8
      send(1'b1, 1'b1); send(1'b0, 1'b1);
      do_reset(2);                                   // R10 mid-stream restart
      for (int k = 0; k < 8; k++) send(k[0], 1'b1);
      send(1'b1, 1'b0); send(1'b0, 1'b0);            // R8 idle at end
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R7 pending actual %0d expected 0", exp_q.size());
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule